// File: doc/BRIEF.md
# Programmable Watchdog with Reset Steering

This block is a watchdog timer configured through one byte-wide register. The low seven bits of the byte pick a timeout as a multiplier and a resolution, and the timeout is counted in sixteenths of a second, using a strobe that pulses at 16 Hz. Software keeps the watchdog quiet by touching the register. A write loads a new setting, and a read reloads the stored one. Either access restarts the countdown and clears the expiry flag.

When the countdown runs out, the block raises a sticky expiry flag. The top bit of the register then picks one of two actions. With the bit set, the block issues a one-cycle system reset request and a one-cycle strobe that clears the century bit in a neighbouring calendar register. It also wipes its own register to zero. With the bit clear, it emits a single interrupt pulse, keeps its setting, and stays idle until software restarts it.

Top module: `wdt_steer`

## Requirements
- R1: The register holds the resolution in bits 1:0 and the multiplier in bits 6:2. The timeout N equals multiplier × 4^resolution tick strobes. Expiry happens on the N-th tick strobe after a restart, and its outputs appear in the following clock cycle.
- R2: A setting whose interval is zero, whether the whole byte is zero or the multiplier alone is zero, never expires, however many ticks arrive.
- R3: A write stores the byte, which then shows on the read-data port, and restarts the countdown with the new interval. This includes a write that arrives while a countdown is already running.
- R4: A read strobe restarts the countdown with the stored interval.
- R5: Every restart clears the expiry flag. Expiry sets it, and it stays set through later ticks until the next restart or a global reset.
- R6: On expiry with bit 7 set, resetReq and centuryClr each pulse high for exactly one cycle and the register becomes 0x00. No interrupt is issued.
- R7: On expiry with bit 7 clear, irqPulse is high for exactly one cycle and the register keeps its value. Further ticks cause no expiry until the next restart.
- R8: A restart in the same cycle as the final tick takes priority. That tick does not expire, and a full new interval begins.
- R9: After reset, the register reads 0x00, the flag is clear and no output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (restarts the countdown) |
| regWrData | input | 8 | Byte to write |
| regRdData | output | 8 | Current register contents |
| tick16 | input | 1 | One-cycle strobe at 16 Hz |
| wdFlag | output | 1 | Sticky expiry flag |
| resetReq | output | 1 | One-cycle system reset request |
| irqPulse | output | 1 | One-cycle interrupt pulse |
| centuryClr | output | 1 | One-cycle strobe to clear the external century bit |

## Verification
A wrong count value, or a wrong count-active state, shows up at the ports as an expiry that comes one or more ticks too early or too late, or that never comes. The bench therefore holds the count one tick short of every nonzero interval and checks that nothing has fired, then gives one more tick and expects the event in the very next cycle. A register or steering fault shows as the wrong pulse kind, or as a read-back value left unchanged after a reset-mode expiry. A counter that fails to go idle shows as a second interrupt within a few ticks.

// File: rtl/wdt_steer_pkg.sv
package wdt_steer_pkg;
  // Strobes from the register control to the counter datapath.
  typedef struct packed {
    logic restart;  // reload the interval (write or read of the register)
    logic countEn;  // one 1/16 s tick
  } wdStrobe_t;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_steer_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrobe_t         ctl,
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic              expireNow
);
  localparam int MAX_RES = (1 << RES_W) - 1;
  localparam int COUNT_W = MULT_W + 2 * MAX_RES;

  logic [COUNT_W-1:0] interval;
  logic [COUNT_W-1:0] cnt;
  logic               active;

  // multiplier times 4^resolution
  assign interval = COUNT_W'(mult) << {res, 1'b0};

  assign expireNow = active && ctl.countEn && !ctl.restart && (cnt == COUNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (ctl.restart) begin
      cnt    <= interval;
      active <= (interval != '0);
    end else if (ctl.countEn && active) begin
      if (cnt == COUNT_W'(1)) begin
        cnt    <= '0;
        active <= 1'b0;
      end else begin
        cnt <= cnt - COUNT_W'(1);
      end
    end
  end

  // R1: each tick moves a running count down by exactly one
  p_count_down_r1: assert property (@(posedge clk) disable iff (!rstN)
    (active && ctl.countEn && !ctl.restart && cnt > COUNT_W'(1)) |=> (cnt == $past(cnt) - COUNT_W'(1)));

  // R2: a zero interval never leaves the counter running
  p_zero_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.restart && mult == '0) |=> !active);

  // R8: a restart always reloads the count, even on a final tick
  p_restart_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> (cnt == $past(interval)));
endmodule

// File: rtl/wdt_regctl.sv
module wdt_regctl
  import wdt_steer_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int REG_W = 1 + MULT_W + RES_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              tick16,
  input  logic              expireNow,
  output wdStrobe_t         ctl,
  output logic [MULT_W-1:0] mult,
  output logic [RES_W-1:0]  res,
  output logic [REG_W-1:0]  regRdData,
  output logic              wdFlag,
  output logic              resetReq,
  output logic              irqPulse,
  output logic              centuryClr
);
  localparam int STEER_BIT = REG_W - 1;

  logic [REG_W-1:0] wdReg;
  logic [REG_W-1:0] cfgSrc;

  assign ctl.restart = regWrEn || regRdEn;
  assign ctl.countEn = tick16;

  // a write must load the new value on the same edge
  assign cfgSrc    = regWrEn ? regWrData : wdReg;
  assign res       = cfgSrc[RES_W-1:0];
  assign mult      = cfgSrc[RES_W +: MULT_W];
  assign regRdData = wdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdReg      <= '0;
      wdFlag     <= 1'b0;
      resetReq   <= 1'b0;
      irqPulse   <= 1'b0;
      centuryClr <= 1'b0;
    end else begin
      resetReq   <= expireNow && wdReg[STEER_BIT];
      centuryClr <= expireNow && wdReg[STEER_BIT];
      irqPulse   <= expireNow && !wdReg[STEER_BIT];
      if (regWrEn)                            wdReg <= regWrData;
      else if (expireNow && wdReg[STEER_BIT]) wdReg <= '0;
      if (ctl.restart)    wdFlag <= 1'b0;
      else if (expireNow) wdFlag <= 1'b1;
    end
  end

  // R6: a reset request always comes with a cleared register
  p_reg_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (wdReg == '0 || $past(regWrEn)));

  // R6: reset steering and interrupt steering never coincide
  p_one_action_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && irqPulse));

  // R7: the interrupt lasts exactly one cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R5: a restart leaves the flag clear
  p_restart_clears_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> !wdFlag);
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_steer_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int REG_W = 1 + MULT_W + RES_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             tick16,
  output logic             wdFlag,
  output logic             resetReq,
  output logic             irqPulse,
  output logic             centuryClr
);
  wdStrobe_t         ctl;
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic              expireNow;

  wdt_regctl #(.MULT_W(MULT_W), .RES_W(RES_W)) uCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .tick16(tick16), .expireNow(expireNow),
    .ctl(ctl), .mult(mult), .res(res), .regRdData(regRdData),
    .wdFlag(wdFlag), .resetReq(resetReq), .irqPulse(irqPulse),
    .centuryClr(centuryClr)
  );

  wdt_counter #(.MULT_W(MULT_W), .RES_W(RES_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mult(mult), .res(res),
    .expireNow(expireNow)
  );

  // R5: the flag only rises together with an expiry action
  p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> (irqPulse || resetReq));

  // R6: century clear and reset request travel together
  p_century_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    centuryClr == resetReq);
endmodule

// File: tb/tb_wdt_steer.sv
module tb_wdt_steer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       tick16 = 1'b0;
  logic       wdFlag, resetReq, irqPulse, centuryClr;

  int checks = 0;
  int failures = 0;
  int irqCnt = 0, rstCnt = 0, clrCnt = 0;

  always #2.5 clk = ~clk;

  wdt_steer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .tick16(tick16),
    .wdFlag(wdFlag), .resetReq(resetReq), .irqPulse(irqPulse),
    .centuryClr(centuryClr)
  );

  always @(negedge clk) begin
    if (irqPulse)   irqCnt++;
    if (resetReq)   rstCnt++;
    if (centuryClr) clrCnt++;
  end

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clrCounts();
    irqCnt = 0; rstCnt = 0; clrCnt = 0;
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg();
    @(negedge clk); regRdEn = 1'b1;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick16 = 1'b1;
      repeat (n) @(negedge clk);
      tick16 = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk); #1;
  endtask

  initial begin
    repeat (100000 + 90000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9: reset state
    chkEq("R9 regRdData", regRdData, 0);
    chkEq("R9 wdFlag", wdFlag, 0);
    chkEq("R9 pulses", resetReq + irqPulse + centuryClr, 0);
    clrCounts();

    // R4: a read reloads the stored interval (mult 1, res 1 -> 4 ticks)
    wrReg(8'h05); clrCounts();
    ticks(3); rdReg(); ticks(3); settle();
    chkEq("R4 no expiry after read reload", irqCnt, 0);
    ticks(1); settle();
    chkEq("R4 expiry after reloaded interval", irqCnt, 1);

    // R5: flag stays set through ticks, cleared by a read
    ticks(5); #1;
    chkEq("R5 flag held", wdFlag, 1);
    rdReg(); #1;
    chkEq("R5 flag cleared by restart", wdFlag, 0);

    // R8: restart on the final tick wins (mult 2, res 0 -> 2 ticks)
    wrReg(8'h08); clrCounts();
    ticks(1);
    @(negedge clk); tick16 = 1'b1; regRdEn = 1'b1;
    @(negedge clk); tick16 = 1'b0; regRdEn = 1'b0;
    settle();
    chkEq("R8 no expiry on colliding tick", irqCnt + wdFlag, 0);
    ticks(1); settle();
    chkEq("R8 still counting", irqCnt, 0);
    ticks(1); settle();
    chkEq("R8 expiry after full new interval", irqCnt, 1);

    // R3: a write mid-count restarts with the new interval
    wrReg(8'h10); clrCounts();
    ticks(2);
    wrReg(8'h08);
    ticks(1); settle();
    chkEq("R3 no early expiry", irqCnt, 0);
    chkEq("R3 readback", regRdData, 8'h08);
    ticks(1); settle();
    chkEq("R3 expiry at new interval", irqCnt, 1);

    // R1 R2 R6 R7: sweep of every register value
    for (int v = 0; v < 256; v++) begin
      automatic int mult = (v >> 2) & 31;
      automatic int res  = v & 3;
      automatic int n    = mult * (1 << (2 * res));
      wrReg(v[7:0]); clrCounts();
      #1;
      chkEq("R3 sweep readback", regRdData, v);
      if (n == 0) begin
        ticks(8); settle();
        chkEq("R2 zero interval idle", irqCnt + rstCnt + wdFlag, 0);
      end else begin
        ticks(n - 1); settle();
        chkEq("R1 silent before last tick", irqCnt + rstCnt + wdFlag, 0);
        ticks(1); settle();
        chkEq("R1 R5 flag set on expiry", wdFlag, 1);
        if (v[7]) begin
          chkEq("R6 reset request once", rstCnt, 1);
          chkEq("R6 century clear once", clrCnt, 1);
          chkEq("R6 no interrupt", irqCnt, 0);
          chkEq("R6 register cleared", regRdData, 0);
        end else begin
          chkEq("R7 interrupt once", irqCnt, 1);
          chkEq("R7 no reset request", rstCnt + clrCnt, 0);
          chkEq("R7 register kept", regRdData, v);
          ticks(3); settle();
          chkEq("R7 idle after expiry", irqCnt, 1);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule